// File: doc/BRIEF.md
# High-Side Transient Pulse Override

This block sits between a digital PWM/PFM modulator and the high-side gate driver of a buck stage. It takes the modulator's high-side request and the two outputs of a window comparator on the regulated voltage, and produces the final registered high-side drive. A low-limit indication starts an extra high-side pulse without waiting for the next switching cycle. An overvoltage indication cuts short any high-side drive and keeps it off until a later sample shows the voltage back under the upper limit.

The comparator outputs are brought in through a two-flop synchronizer and evaluated only on sample ticks. There are four ticks per switching period: one on the cycle-start strobe, then one every quarter period. The injected pulse length can be programmed in system clocks, and a programmed value of zero selects one quarter period. The override acts the same way in both modulator modes. With the enable input low, the block only registers the modulator request.

Top module: `hs_transient_override`

## Requirements
- R1: With `enable` low, `hsDrive` equals `hsReq` of the previous clock, the comparator inputs have no effect, and any pending pulse and blanking are dropped.
- R2: `cmpLow` and `cmpHigh` pass through two flops before use. They are evaluated only on sample ticks: the cycle in which `cycleStart` is high, and every q = max(`periodClks`/4, 1) clocks after it. Between ticks, and with no override active, `hsDrive` follows `hsReq` one clock later.
- R3: An undervoltage (`cmpLow` = 1) seen on a tick with `enable` high and no overvoltage loads an injected pulse at once, without waiting for `cycleStart`. `hsDrive` goes high from the second clock after the tick whatever `hsReq` is.
- R4: If the undervoltage is still present on the tick that comes with `cycleStart`, a new injected pulse is ORed onto the modulator request.
- R5: The injected pulse lasts `pulseClks` clocks, or q clocks when `pulseClks` is 0, counted from the tick that loaded it. A later undervoltage tick reloads the full length.
- R6: An overvoltage (`cmpHigh` = 1) seen on a tick with `enable` high blanks `hsDrive` from the second clock after the tick. This ends both the modulator pulse and any injected pulse in progress, and a cancelled injected pulse does not resume.
- R7: Blanking lasts until a later tick sees `cmpHigh` low.
- R8: When both comparator outputs are high on the same tick, blanking wins: the output is held low and no pulse is loaded.
- R9: `pwmMode` has no effect on `hsDrive`.
- R10: A synchronous active-low `rstN` clears the synchronizer, the pulse counter and the blanking state, and drives `hsDrive` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Override enable; low gives plain pass-through |
| pwmMode | input | 1 | Modulator mode indication (1 = PWM, 0 = PFM) |
| cycleStart | input | 1 | One-clock strobe at the start of each switching period |
| hsReq | input | 1 | High-side request from the modulator |
| cmpLow | input | 1 | Comparator output, high when the voltage is below the lower limit |
| cmpHigh | input | 1 | Comparator output, high when the voltage is above the upper limit |
| periodClks | input | CNT_W | Switching period in system clocks |
| pulseClks | input | CNT_W | Injected pulse length in clocks, 0 selects a quarter period |
| hsDrive | output | 1 | Registered final high-side drive |

## Verification
On every cycle the assertions check that blanking forces the output low and outlasts the gaps between ticks, that an active injected pulse drives the output high, and that a tick with both flags set gives blanking with no pulse. They also check the one-clock pass-through while disabled, pass-through across a mode change, and the reset state. The exact tick positions, the pulse lengths measured in clocks, retriggering at cycle start and the cancellation of pulses can only be seen in the bench scenarios. The same holds for showing that a mode-swapped run gives a bit-identical output.

// File: rtl/hto_pkg.sv
package hto_pkg;

  // Strobes issued by the control to the datapath each clock.
  typedef struct packed {
    logic loadPulse;   // start a fresh injected pulse
    logic clearPulse;  // abandon any injected pulse in progress
    logic blank;       // suppress all high-side drive
  } ctrlStrobes_t;

  // Event seen on a sample tick, for readable decoding in the control.
  typedef enum logic [1:0] {
    EV_NONE  = 2'b00,
    EV_UNDER = 2'b01,
    EV_OVER  = 2'b10,
    EV_BOTH  = 2'b11
  } sampleEvent_e;

endpackage

// File: rtl/hto_sample_timer.sv
module hto_sample_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cycleStart,
  input  logic [CNT_W-1:0] periodClks,
  output logic             sampleTick,
  output logic [CNT_W-1:0] quarterClks
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] rawQuarter;
  logic [CNT_W-1:0] lastCount;
  logic [CNT_W-1:0] subCnt;

  // A period shorter than four clocks still yields one tick per clock.
  always_comb begin
    rawQuarter  = periodClks >> 2;
    quarterClks = (rawQuarter == '0) ? ONE : rawQuarter;
    lastCount   = quarterClks - ONE;
  end

  // The cycle start realigns the quarter grid; the >= guards against a
  // period change that would leave the counter beyond the new limit.
  assign sampleTick = cycleStart | (subCnt >= lastCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt <= '0;
    end else if (sampleTick) begin
      subCnt <= '0;
    end else begin
      subCnt <= subCnt + ONE;
    end
  end

endmodule

// File: rtl/hto_datapath.sv
module hto_datapath
  import hto_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             hsReq,
  input  logic             cmpLow,
  input  logic             cmpHigh,
  input  logic [CNT_W-1:0] pulseClks,
  input  logic [CNT_W-1:0] quarterClks,
  input  ctrlStrobes_t     strobes,
  output logic             lowSync,
  output logic             highSync,
  output logic             injectActive,
  output logic             hsDrive
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam int NUM_CMP = 2;

  logic [NUM_CMP-1:0] cmpRaw;
  logic [NUM_CMP-1:0] cmpSynced;
  logic [CNT_W-1:0]   pulseLen;
  logic [CNT_W-1:0]   pulseCnt;
  logic               driveNext;

  assign cmpRaw = {cmpHigh, cmpLow};

  // One synchronizer chain per comparator output.
  for (genvar b = 0; b < NUM_CMP; b++) begin : gSync
    logic [SYNC_DEPTH-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain <= '0;
      end else begin
        chain <= {chain[SYNC_DEPTH-2:0], cmpRaw[b]};
      end
    end
    assign cmpSynced[b] = chain[SYNC_DEPTH-1];
  end

  assign lowSync  = cmpSynced[0];
  assign highSync = cmpSynced[1];

  // Injected pulse length: programmed count, or a quarter period when zero.
  assign pulseLen = (pulseClks == '0) ? quarterClks : pulseClks;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobes.clearPulse) begin
      pulseCnt <= '0;
    end else if (strobes.loadPulse) begin
      pulseCnt <= pulseLen;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - ONE;
    end
  end

  assign injectActive = (pulseCnt != '0);

  // Final gating: blanking dominates every pulse source.
  always_comb begin
    if (enable) begin
      driveNext = (hsReq | injectActive) & ~strobes.blank;
    end else begin
      driveNext = hsReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsDrive <= 1'b0;
    end else begin
      hsDrive <= driveNext;
    end
  end

endmodule

// File: rtl/hto_control.sv
module hto_control
  import hto_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         sampleTick,
  input  logic         lowSync,
  input  logic         highSync,
  output ctrlStrobes_t strobes
);

  sampleEvent_e tickEvent;
  logic         blankQ;
  logic         blankNext;

  // Decode the flags only on a tick while enabled.
  always_comb begin
    if (enable && sampleTick) begin
      tickEvent = sampleEvent_e'({highSync, lowSync});
    end else begin
      tickEvent = EV_NONE;
    end
  end

  // Blanking state is re-decided on each tick and held in between.
  always_comb begin
    blankNext = blankQ;
    if (!enable) begin
      blankNext = 1'b0;
    end else if (sampleTick) begin
      blankNext = (tickEvent == EV_OVER) || (tickEvent == EV_BOTH);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blankQ <= 1'b0;
    end else begin
      blankQ <= blankNext;
    end
  end

  always_comb begin
    strobes.blank      = blankQ;
    strobes.loadPulse  = (tickEvent == EV_UNDER);
    strobes.clearPulse = !enable || (tickEvent == EV_OVER) || (tickEvent == EV_BOTH);
  end

endmodule

// File: rtl/hs_transient_override.sv
module hs_transient_override
  import hto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             pwmMode,
  input  logic             cycleStart,
  input  logic             hsReq,
  input  logic             cmpLow,
  input  logic             cmpHigh,
  input  logic [CNT_W-1:0] periodClks,
  input  logic [CNT_W-1:0] pulseClks,
  output logic             hsDrive
);

  localparam int SYNC_DEPTH = 2;

  logic             sampleTick;
  logic [CNT_W-1:0] quarterClks;
  logic             lowSync;
  logic             highSync;
  logic             injectActive;
  logic             blankState;
  ctrlStrobes_t     strobes;

  hto_sample_timer #(.CNT_W(CNT_W)) uTimer (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStart (cycleStart),
    .periodClks (periodClks),
    .sampleTick (sampleTick),
    .quarterClks(quarterClks)
  );

  hto_control uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .sampleTick(sampleTick),
    .lowSync   (lowSync),
    .highSync  (highSync),
    .strobes   (strobes)
  );

  hto_datapath #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .hsReq       (hsReq),
    .cmpLow      (cmpLow),
    .cmpHigh     (cmpHigh),
    .pulseClks   (pulseClks),
    .quarterClks (quarterClks),
    .strobes     (strobes),
    .lowSync     (lowSync),
    .highSync    (highSync),
    .injectActive(injectActive),
    .hsDrive     (hsDrive)
  );

  assign blankState = strobes.blank;

endmodule

// File: rtl/hto_checker.sv
module hto_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic pwmMode,
  input logic hsReq,
  input logic hsDrive,
  input logic sampleTick,
  input logic uvSeen,
  input logic ovSeen,
  input logic blankState,
  input logic injectActive
);

  AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (hsDrive == $past(hsReq))); // R1

  AST_UV_LOADS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && enable && uvSeen && !ovSeen) |=> injectActive); // R3

  AST_INJECT_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (injectActive && !blankState && enable) |=> hsDrive); // R3

  AST_BLANK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (blankState && enable) |=> !hsDrive); // R6

  AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (blankState && enable && !sampleTick) |=> blankState); // R7

  AST_BOTH_FLAGS_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && enable && uvSeen && ovSeen) |=> (blankState && !injectActive)); // R8

  AST_MODE_NEUTRAL: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (pwmMode != $past(pwmMode)) && !blankState && !injectActive)
      |=> (hsDrive == $past(hsReq))); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (!hsDrive && !blankState && !injectActive)); // R10

endmodule

bind hs_transient_override hto_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .pwmMode     (pwmMode),
  .hsReq       (hsReq),
  .hsDrive     (hsDrive),
  .sampleTick  (sampleTick),
  .uvSeen      (lowSync),
  .ovSeen      (highSync),
  .blankState  (blankState),
  .injectActive(injectActive)
);

// File: tb/tb_hs_transient_override.sv
`timescale 1ns/1ps
module tb_hs_transient_override;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         enable = 1'b0;
  logic         pwmMode = 1'b1;
  logic         cycleStart = 1'b0;
  logic         hsReq = 1'b0;
  logic         cmpLow = 1'b0;
  logic         cmpHigh = 1'b0;
  logic [W-1:0] periodClks = 16'd32;
  logic [W-1:0] pulseClks = 16'd0;
  logic         hsDrive;

  int  nChecks = 0;
  int  nFail = 0;
  bit  monOn = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hs_transient_override #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .pwmMode(pwmMode),
    .cycleStart(cycleStart), .hsReq(hsReq), .cmpLow(cmpLow), .cmpHigh(cmpHigh),
    .periodClks(periodClks), .pulseClks(pulseClks), .hsDrive(hsDrive)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // ---------------- reference model, built from the requirements ----------------
  int    mSince, mPulse;
  bit    mS1L, mS2L, mS1H, mS2H, mBlank, mFromStart, mBoth;
  bit    expOut;
  string expTag = "R10";

  function automatic int quarterOf(input logic [W-1:0] per);
    int q = int'(per >> 2);
    return (q < 1) ? 1 : q;
  endfunction

  always @(posedge clk) begin
    int q, cur;
    bit tick, uv, ov;
    if (!rstN) begin
      mSince = 0; mPulse = 0; mS1L = 0; mS2L = 0; mS1H = 0; mS2H = 0;
      mBlank = 0; mFromStart = 0; mBoth = 0; expOut = 0; expTag = "R10";
    end else begin
      expOut = enable ? ((hsReq || mPulse != 0) && !mBlank) : hsReq;
      if (!enable)          expTag = "R1";
      else if (mBoth)       expTag = "R8";
      else if (mBlank)      expTag = "R6";
      else if (mPulse != 0) expTag = mFromStart ? "R4" : "R3";
      else                  expTag = "R2";
      q    = quarterOf(periodClks);
      cur  = cycleStart ? 0 : mSince + 1;
      mSince = cur;
      tick = (cur % q) == 0;
      uv   = enable && mS2L;
      ov   = enable && mS2H;
      if (!enable) begin
        mPulse = 0; mBlank = 0; mBoth = 0;
      end else if (tick) begin
        mBlank = ov;
        mBoth  = uv && ov;
        if (ov) mPulse = 0;
        else if (uv) begin
          mPulse = (pulseClks == 0) ? q : int'(pulseClks);
          mFromStart = cycleStart;
        end else if (mPulse > 0) mPulse--;
      end else if (mPulse > 0) mPulse--;
      mS2L = mS1L; mS1L = cmpLow;
      mS2H = mS1H; mS1H = cmpHigh;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (monOn) check(hsDrive === expOut, expTag, int'(hsDrive), int'(expOut));
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cycleStart = 0; hsReq = 0; cmpLow = 0; cmpHigh = 0;
    repeat (3) @(negedge clk);
    check(hsDrive === 1'b0, "R10 reset drive", int'(hsDrive), 0);
    rstN = 1'b1;
    monOn = 1'b1;
  endtask

  // Count high cycles of hsDrive after one undervoltage tick (R5).
  task automatic measurePulse(input logic [W-1:0] len, input int expected);
    int highs = 0;
    enable = 1; periodClks = 16'd32; pulseClks = len;
    doReset();
    cmpLow = 1;
    repeat (8) @(negedge clk);  // the synced level spans exactly one tick
    cmpLow = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hsDrive === 1'b1) highs++;
    end
    check(highs == expected, "R5 pulse length", highs, expected);
  endtask

  bit rec [2][160];

  initial begin
    int pos, per, duty, burst;
    void'($urandom(32'h5EED_0042));
    doReset();

    // R5 directed: programmed and default lengths
    measurePulse(16'd5, 5);
    measurePulse(16'd0, 8);
    measurePulse(16'd3, 3);

    // R7 directed: long overvoltage with a constant request
    enable = 1; pulseClks = 0; doReset();
    hsReq = 1; cmpHigh = 1;
    repeat (12) @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(hsDrive === 1'b0, "R7 held blank", int'(hsDrive), 0);
    end
    cmpHigh = 0;
    repeat (14) @(negedge clk);
    check(hsDrive === 1'b1, "R7 release", int'(hsDrive), 1);

    // R9 directed: identical stimulus in both modes
    for (int m = 0; m < 2; m++) begin
      pwmMode = m[0]; enable = 1; periodClks = 16'd32; pulseClks = 16'd0;
      doReset();
      for (int i = 0; i < 160; i++) begin
        cycleStart = (i % 32) == 0;
        hsReq  = (i % 32) < 6;
        cmpLow = ((i % 37) >= 5) && ((i % 37) < 15);
        cmpHigh = ((i % 53) >= 20) && ((i % 53) < 29);
        @(negedge clk);
        rec[m][i] = hsDrive;
      end
    end
    begin
      int diffs = 0;
      for (int i = 0; i < 160; i++) if (rec[0][i] != rec[1][i]) diffs++;
      check(diffs == 0, "R9 mode-independent output", diffs, 0);
    end

    // Constrained random mix checked cycle by cycle against the model
    enable = 1; periodClks = 16'd32; doReset();
    pos = 0; per = 32; duty = 8; burst = 0;
    for (int i = 0; i < 6000; i++) begin
      if (pos == 0) begin
        cycleStart = 1;
        if ($urandom % 6 == 0) begin
          case ($urandom % 3)
            0: periodClks = 16'd16;
            1: periodClks = 16'd20;
            default: periodClks = 16'd32;
          endcase
        end
        per  = int'(periodClks);
        duty = int'($urandom % (per / 2 + 1));
        if (!pwmMode && ($urandom % 3 == 0)) duty = 0;
        if ($urandom % 10 == 0) pwmMode = ~pwmMode;
      end else begin
        cycleStart = 0;
      end
      hsReq = pos < duty;
      pos = (pos + 1) % per;
      if (burst == 0) begin
        case ($urandom % 10)
          0, 1, 2, 3, 4: begin cmpLow = 0; cmpHigh = 0; end
          5, 6, 7:       begin cmpLow = 1; cmpHigh = 0; end
          8:             begin cmpLow = 0; cmpHigh = 1; end
          default:       begin cmpLow = 1; cmpHigh = 1; end
        endcase
        burst = 1 + int'($urandom % 24);
      end else burst--;
      if (enable && ($urandom % 300 == 0)) enable = 0;
      else if (!enable && ($urandom % 25 == 0)) enable = 1;
      if ($urandom % 150 == 0) begin
        case ($urandom % 3)
          0: pulseClks = 16'd0;
          1: pulseClks = 16'd3;
          default: pulseClks = 16'd11;
        endcase
      end
      if (i == 4000) begin
        // R10 mid-run reset
        rstN = 0;
        @(negedge clk);
        @(negedge clk);
        check(hsDrive === 1'b0, "R10 mid-run reset", int'(hsDrive), 0);
        rstN = 1;
        pos = 0;
      end
      @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule